// File: doc/BRIEF.md
# Zero-suppressing hit finder

This block receives one row of a pixel sensor at a time as a stream of digitised double samples, one channel per accepted cycle. For each channel it subtracts the pedestal-only sample from the signal-plus-pedestal sample, clamps a negative result to zero and compares it with a threshold. Only channels above the threshold are kept. In neighbour mode, the channels on each side of a hit are also kept. Each kept channel becomes one entry in a hit buffer, and a serial framer shifts the entries out one after another.

A row begins with a pulse on `row_start`, which also latches the row number. The channel number is the count of samples accepted since that pulse. When the buffer is full, entries are lost and a sticky flag records the loss until the next row begins.

Top module: `zs_hit_finder`

## Requirements
- R1: The value of a channel is `samp_sig - samp_ped`. A negative difference is replaced by zero, and the result is `SAMPLE_W` bits wide.
- R2: A channel is a hit only when its value is strictly greater than `threshold`. A value equal to the threshold is not a hit.
- R3: With `nbr_en` low, exactly the hit channels produce entries.
- R4: With `nbr_en` high, a channel produces one entry if it is a hit or if the channel directly below or above it is a hit. No channel appears twice. Channel 0 has no lower neighbour and channel `NUM_CH-1` has no upper neighbour.
- R5: Within a row, entries leave in ascending channel order. Rows leave in the order they arrived.
- R6: Each entry is the 27-bit word {row[7:0], channel[6:0], value[11:0]}, sent MSB first on `ser_data`. `ser_frame` is high for exactly 27 consecutive cycles per entry, and it stays low for at least two cycles between entries.
- R7: The channel number counts accepted samples from 0 after `row_start`, and the row field is the `row_idx` latched at `row_start`. Samples beyond the `NUM_CH`-th in a row are ignored and produce no entry. `row_start` must come at least four cycles after the last sample of the previous row.
- R8: An entry that arrives while the buffer holds `FIFO_DEPTH` entries is dropped and `overflow` is set. `overflow` then stays high until the next `row_start`, which clears it.
- R9: After reset, `ser_frame` and `overflow` are low and nothing is emitted until a hit is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | Starts a new row, clears the channel count and the overflow flag |
| row_idx | input | ROW_W | Row number, latched on `row_start` |
| samp_valid | input | 1 | A sample pair is present for the next channel |
| samp_sig | input | SAMPLE_W | Signal-plus-pedestal sample |
| samp_ped | input | SAMPLE_W | Pedestal-only sample |
| threshold | input | SAMPLE_W | Hit threshold, compared strictly |
| nbr_en | input | 1 | Also keep the neighbours of hits |
| ser_data | output | 1 | Serial entry bit, MSB first |
| ser_frame | output | 1 | High while an entry is being shifted |
| overflow | output | 1 | Sticky flag for entries lost in the current row |

## Verification
The hardest state to reach is a full buffer while the serial framer is draining it. Once an entry leaves, space frees and a later channel of the same row can be accepted after others were dropped, so the set of entries that survive depends on timing. The bench reaches this state by marking all 128 channels of one row as hits and delivering them back to back. It then accepts any ordered subset of the expected entries that starts with the first `FIFO_DEPTH` channels, checks that the surviving count lies within a bound set by the drain rate, and checks that the flag holds until the next row start clears it. Neighbour mode is exercised with hits at both boundary channels, on adjacent channels, and on channels two apart that share one neighbour.

// File: rtl/hf_pkg.sv
package hf_pkg;
  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_FETCH = 2'd1,
    SER_SHIFT = 2'd2
  } ser_state_e;
endpackage

// File: rtl/hf_cds.sv
// Stage 1: channel counting, correlated difference, clamp and compare.
module hf_cds #(
  parameter int NUM_CH   = 128,
  parameter int SAMPLE_W = 12,
  parameter int ROW_W    = 8,
  parameter int CH_W     = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                row_start,
  input  logic [ROW_W-1:0]    row_idx,
  input  logic                samp_valid,
  input  logic [SAMPLE_W-1:0] samp_sig,
  input  logic [SAMPLE_W-1:0] samp_ped,
  input  logic [SAMPLE_W-1:0] threshold,
  output logic                s1_vld,
  output logic [CH_W-1:0]     s1_ch,
  output logic [ROW_W-1:0]    s1_row,
  output logic [SAMPLE_W-1:0] s1_val,
  output logic                s1_hit,
  output logic                s1_last
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0]     ch_cnt;
  logic                row_done;
  logic [ROW_W-1:0]    row_q;
  logic signed [SAMPLE_W:0] diff;
  logic [SAMPLE_W-1:0] val;
  logic                accept;

  // R1: one extra bit holds the sign of the difference
  assign diff   = $signed({1'b0, samp_sig}) - $signed({1'b0, samp_ped});
  assign val    = diff[SAMPLE_W] ? '0 : diff[SAMPLE_W-1:0];
  assign accept = samp_valid && !row_done && !row_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_cnt   <= '0;
      row_done <= 1'b0;
      row_q    <= '0;
      s1_vld   <= 1'b0;
    end else begin
      s1_vld <= accept;
      if (row_start) begin
        ch_cnt   <= '0;
        row_done <= 1'b0;
        row_q    <= row_idx;
      end else if (accept) begin
        if (ch_cnt == LAST_CH) row_done <= 1'b1;
        else                   ch_cnt   <= ch_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    s1_ch   <= ch_cnt;
    s1_row  <= row_q;
    s1_val  <= val;
    s1_hit  <= (val > threshold);
    s1_last <= (ch_cnt == LAST_CH);
  end

  // R2: a flagged hit always lies strictly above the threshold it met
  a_r2_hit_above: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_hit) |-> (s1_val > $past(threshold)));

  // R7: samples after the last channel of a row are not accepted
  a_r7_extra_ignored: assert property (@(posedge clk) disable iff (rst)
    (row_done && samp_valid && !row_start) |=> !s1_vld);
endmodule

// File: rtl/hf_nbr.sv
// Stage 2: three-channel window that decides which channels to keep.
module hf_nbr #(
  parameter int SAMPLE_W = 12,
  parameter int ROW_W    = 8,
  parameter int CH_W     = 7,
  parameter int ENTRY_W  = ROW_W + CH_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                row_start,
  input  logic                nbr_en,
  input  logic                s1_vld,
  input  logic [CH_W-1:0]     s1_ch,
  input  logic [ROW_W-1:0]    s1_row,
  input  logic [SAMPLE_W-1:0] s1_val,
  input  logic                s1_hit,
  input  logic                s1_last,
  output logic                wr_vld,
  output logic [ENTRY_W-1:0]  wr_data
);
  logic                p_vld, p_hit, pp_hit, flush;
  logic [CH_W-1:0]     p_ch;
  logic [ROW_W-1:0]    p_row;
  logic [SAMPLE_W-1:0] p_val;
  logic                next_hit, decide, keep;

  // Channel p is decided once the channel above it arrives,
  // or in the flush cycle after the last channel of a row.
  assign next_hit = s1_vld && s1_hit;
  assign decide   = (s1_vld || flush) && p_vld;
  assign keep     = p_hit || (nbr_en && (pp_hit || next_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld  <= 1'b0;
      pp_hit <= 1'b0;
      flush  <= 1'b0;
      wr_vld <= 1'b0;
    end else begin
      wr_vld <= decide && keep;
      flush  <= s1_vld && s1_last;
      if (row_start) begin
        p_vld  <= 1'b0;
        pp_hit <= 1'b0;
      end else if (s1_vld) begin
        p_vld  <= 1'b1;
        pp_hit <= p_vld && p_hit;
      end else if (flush) begin
        p_vld  <= 1'b0;
        pp_hit <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      p_ch  <= s1_ch;
      p_row <= s1_row;
      p_val <= s1_val;
      p_hit <= s1_hit;
    end
    wr_data <= {p_row, p_ch, p_val};
  end

  // Checker state: last channel written in this row
  logic            have_last;
  logic [CH_W-1:0] last_ch;
  always_ff @(posedge clk) begin
    if (rst || row_start) begin
      have_last <= 1'b0;
      last_ch   <= '0;
    end else if (wr_vld) begin
      have_last <= 1'b1;
      last_ch   <= wr_data[SAMPLE_W +: CH_W];
    end
  end

  // R4, R5: strictly ascending channels within a row, so no duplicates
  a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && have_last) |-> (wr_data[SAMPLE_W +: CH_W] > last_ch));
endmodule

// File: rtl/hf_fifo.sv
// Hit buffer: synchronous write, registered read, suited to block RAM.
// DEPTH must be a power of two so the pointers wrap naturally.
module hf_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          full, do_wr, do_rd;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign drop  = wr_en && full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
    if (do_rd) rd_data   <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: a write into a full buffer does not enter it
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !do_rd) |=> full);
endmodule

// File: rtl/hf_ser.sv
// Serial framer: pops one entry, then shifts it out MSB first.
module hf_ser
  import hf_pkg::*;
#(
  parameter int W    = 27,
  localparam int BCW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rd_data,
  input  logic         empty,
  output logic         rd_en,
  output logic         ser_data,
  output logic         ser_frame
);
  ser_state_e     state;
  logic [W-1:0]   shreg;
  logic [BCW-1:0] bitcnt;

  assign rd_en    = (state == SER_IDLE) && !empty;
  assign ser_data = shreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SER_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      ser_frame <= 1'b0;
    end else begin
      case (state)
        SER_IDLE: begin
          ser_frame <= 1'b0;
          if (!empty) state <= SER_FETCH;
        end
        SER_FETCH: begin
          shreg     <= rd_data;
          bitcnt    <= BCW'(W - 1);
          ser_frame <= 1'b1;
          state     <= SER_SHIFT;
        end
        SER_SHIFT: begin
          if (bitcnt == '0) begin
            ser_frame <= 1'b0;
            state     <= SER_IDLE;
          end else begin
            shreg  <= shreg << 1;
            bitcnt <= bitcnt - 1'b1;
          end
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

  // R6: at least two idle cycles separate frames
  a_r6_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_frame) |=> !ser_frame);
endmodule

// File: rtl/zs_hit_finder.sv
module zs_hit_finder #(
  parameter int NUM_CH     = 128,
  parameter int SAMPLE_W   = 12,
  parameter int ROW_W      = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int ENTRY_W   = ROW_W + CH_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                row_start,
  input  logic [ROW_W-1:0]    row_idx,
  input  logic                samp_valid,
  input  logic [SAMPLE_W-1:0] samp_sig,
  input  logic [SAMPLE_W-1:0] samp_ped,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic                nbr_en,
  output logic                ser_data,
  output logic                ser_frame,
  output logic                overflow
);
  logic                s1_vld, s1_hit, s1_last;
  logic [CH_W-1:0]     s1_ch;
  logic [ROW_W-1:0]    s1_row;
  logic [SAMPLE_W-1:0] s1_val;
  logic                wr_vld, rd_en, empty, drop;
  logic [ENTRY_W-1:0]  wr_data, rd_data;

  hf_cds #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .ROW_W(ROW_W), .CH_W(CH_W)) u_cds (
    .clk(clk), .rst(rst), .row_start(row_start), .row_idx(row_idx),
    .samp_valid(samp_valid), .samp_sig(samp_sig), .samp_ped(samp_ped),
    .threshold(threshold), .s1_vld(s1_vld), .s1_ch(s1_ch), .s1_row(s1_row),
    .s1_val(s1_val), .s1_hit(s1_hit), .s1_last(s1_last));

  hf_nbr #(.SAMPLE_W(SAMPLE_W), .ROW_W(ROW_W), .CH_W(CH_W), .ENTRY_W(ENTRY_W)) u_nbr (
    .clk(clk), .rst(rst), .row_start(row_start), .nbr_en(nbr_en),
    .s1_vld(s1_vld), .s1_ch(s1_ch), .s1_row(s1_row), .s1_val(s1_val),
    .s1_hit(s1_hit), .s1_last(s1_last), .wr_vld(wr_vld), .wr_data(wr_data));

  hf_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_vld), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .drop(drop));

  hf_ser #(.W(ENTRY_W)) u_ser (
    .clk(clk), .rst(rst), .rd_data(rd_data), .empty(empty), .rd_en(rd_en),
    .ser_data(ser_data), .ser_frame(ser_frame));

  always_ff @(posedge clk) begin
    if (rst || row_start) overflow <= 1'b0;
    else if (drop)        overflow <= 1'b1;
  end

  // R8: the flag holds within a row and clears at a row start
  a_r8_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (overflow && !row_start) |=> overflow);
  a_r8_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    row_start |=> !overflow);
endmodule

// File: tb/sim_zs_hit_finder.sv
module sim_zs_hit_finder;
  localparam int NCH = 128, SW = 12, RW = 8, CW = 7, EW = 27, DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, row_start, samp_valid, nbr_en;
  logic [RW-1:0] row_idx;
  logic [SW-1:0] samp_sig, samp_ped, threshold;
  logic ser_data, ser_frame, overflow;

  zs_hit_finder u0 (
    .clk(clk), .rst(rst), .row_start(row_start), .row_idx(row_idx),
    .samp_valid(samp_valid), .samp_sig(samp_sig), .samp_ped(samp_ped),
    .threshold(threshold), .nbr_en(nbr_en), .ser_data(ser_data),
    .ser_frame(ser_frame), .overflow(overflow));

  int n_chk = 0, n_fail = 0;
  logic [EW-1:0] exp_q[$];
  int sig_a[NCH], ped_a[NCH];
  bit lossy = 1'b0;
  int rcv_cnt = 0;
  logic [EW-1:0] shv = '0;
  int run = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Collector: rebuilds entries from the serial line and compares them
  always @(negedge clk) begin
    if (!rst) begin
      if (ser_frame) begin
        shv = {shv[EW-2:0], ser_data};
        run++;
      end else if (run != 0) begin
        check(run == EW, "R6 frame length", run, EW);
        if (lossy)
          while (exp_q.size() > 0 && exp_q[0] != shv) void'(exp_q.pop_front());
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R4 unexpected entry", int'(shv), -1);
        end else begin
          check(exp_q[0] == shv, "R5/R6 entry content", int'(shv), int'(exp_q[0]));
          void'(exp_q.pop_front());
        end
        rcv_cnt++;
        run = 0;
      end
    end
  end

  // Reference: R1 clamp, R2 strict compare, R3/R4 selection, R5 order
  task automatic model_row(input int row, input bit nbr, input int thr);
    bit hit[NCH];
    for (int i = 0; i < NCH; i++) begin
      int d = sig_a[i] - ped_a[i];
      if (d < 0) d = 0;
      hit[i] = (d > thr);
    end
    for (int i = 0; i < NCH; i++) begin
      int d = sig_a[i] - ped_a[i];
      bit k = hit[i];
      if (d < 0) d = 0;
      if (nbr && i > 0 && hit[i-1]) k = 1'b1;
      if (nbr && i < NCH-1 && hit[i+1]) k = 1'b1;
      if (k) exp_q.push_back({RW'(row), CW'(i), SW'(d)});
    end
  endtask

  task automatic start_row(input int row);
    row_start = 1'b1; row_idx = RW'(row);
    @(negedge clk);
    row_start = 1'b0;
  endtask

  task automatic feed(input int nsamp, input bit gappy);
    for (int i = 0; i < nsamp; i++) begin
      if (gappy && (i % 3 == 2)) begin
        samp_valid = 1'b0;
        @(negedge clk);
      end
      samp_valid = 1'b1;
      samp_sig = (i < NCH) ? SW'(sig_a[i]) : SW'(4000);
      samp_ped = (i < NCH) ? SW'(ped_a[i]) : SW'(0);
      @(negedge clk);
    end
    samp_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic drain();
    int quiet = 0;
    while (quiet < 40) begin
      @(negedge clk);
      if (ser_frame) quiet = 0; else quiet++;
    end
  endtask

  task automatic fill(input int ped, input int delta);
    for (int i = 0; i < NCH; i++) begin
      ped_a[i] = ped;
      sig_a[i] = ped + delta;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; row_start = 1'b0; row_idx = '0; samp_valid = 1'b0;
    samp_sig = '0; samp_ped = '0; threshold = SW'(100); nbr_en = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ser_frame == 1'b0, "R9 frame idle after reset", ser_frame, 0);
    check(overflow == 1'b0, "R9 overflow low after reset", overflow, 0);
    repeat (10) @(negedge clk);
    check(ser_frame == 1'b0, "R9 no output without hits", ser_frame, 0);

    // Row A: R1 clamp, R2 equal-to-threshold, R3 no neighbours
    fill(200, 3);
    sig_a[5] = 300; sig_a[6] = 301; sig_a[7] = 150;
    ped_a[40] = 0; sig_a[40] = 4095;
    sig_a[90] = 0; ped_a[90] = 4095;
    sig_a[100] = 700; ped_a[127] = 10; sig_a[127] = 1000;
    nbr_en = 1'b0; threshold = SW'(100);
    model_row(7, 1'b0, 100);
    check(exp_q.size() == 4, "R2 model hit count", exp_q.size(), 4);
    start_row(7); feed(NCH, 1'b0); drain();
    check(exp_q.size() == 0, "R1/R2/R3 all entries delivered", exp_q.size(), 0);

    // Row B: R4 neighbours at the edges, adjacent and shared
    for (int i = 0; i < NCH; i++) begin
      ped_a[i] = 100 + i;
      sig_a[i] = ped_a[i] + (i % 7);
    end
    foreach (sig_a[i])
      if (i == 0 || i == 10 || i == 11 || i == 20 || i == 22 || i == 50 || i == 127)
        sig_a[i] = ped_a[i] + 500;
    nbr_en = 1'b1;
    model_row(200, 1'b1, 100);
    check(exp_q.size() == 16, "R4 model entry count", exp_q.size(), 16);
    start_row(200); feed(NCH, 1'b0); drain();
    check(exp_q.size() == 0, "R4 neighbour entries delivered", exp_q.size(), 0);

    // Row C: R7 gapped input, extra samples ignored, threshold 50
    fill(1000, 0);
    sig_a[3] = 1051; sig_a[64] = 1050; sig_a[126] = 1100;
    nbr_en = 1'b0; threshold = SW'(50);
    model_row(33, 1'b0, 50);
    start_row(33); feed(NCH + 4, 1'b1); drain();
    check(exp_q.size() == 0, "R7 extras ignored, entries delivered", exp_q.size(), 0);

    // Row D: R8 overflow with every channel a hit
    fill(0, 600); threshold = SW'(100);
    model_row(90, 1'b0, 100);
    lossy = 1'b1; rcv_cnt = 0;
    start_row(90); feed(NCH, 1'b0);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    drain();
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    check(rcv_cnt >= DEPTH && rcv_cnt <= DEPTH + 8, "R8 surviving entries", rcv_cnt, DEPTH);
    exp_q.delete(); lossy = 1'b0;

    // Row E: R8 clear on row start, R4 upper boundary
    fill(50, 0);
    sig_a[1] = 300; sig_a[127] = 300;
    nbr_en = 1'b1;
    model_row(91, 1'b1, 100);
    start_row(91);
    check(overflow == 1'b0, "R8 overflow cleared by row start", overflow, 0);
    feed(NCH, 1'b0); drain();
    check(exp_q.size() == 0, "R4 boundary entries delivered", exp_q.size(), 0);
    check(overflow == 1'b0, "R8 no overflow on light row", overflow, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule